// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target device has wedged by holding SDA low after it lost track of a transfer. When it receives a start strobe while idle, it takes the SCL and SDA pins away from the normal controller and drives them as open-drain lines. A line is pulled low by asserting its output enable. It is released high by dropping that enable, and the data value is always zero. The block clocks SCL for as long as the synchronised SDA level stays low. Before every clock pulse it waits for SCL to read high, so that a target stretching the clock is given time to let go. Once SDA is free it sends a START condition followed by a STOP condition so that every target's state machine returns to idle.

At the end, whether the recovery worked or not, it releases both lines and hands them back. It signals completion with a one-cycle done pulse and a one-cycle request to reinitialise the normal controller. An error flag records a failed recovery and stays set until the next accepted start. The interval between line changes is a parameter in clock cycles. Both retry loops have bounds: the number of recovery pulses and the number of low polls during a stretch wait. The block has no data stream, so every pin is a plain control or status level.

Top module: `i2c_unwedge_seq`

## Requirements
- R1: While reset is asserted and right after it, both output enables, `owns_bus_o`, `done_o`, `reinit_req_o` and `error_o` are 0.
- R2: A `start_i` sampled high while the block is idle makes `owns_bus_o` 1 from the next cycle. A `start_i` that arrives while a sequence runs has no effect on the sequence and yields no extra done pulse.
- R3: `scl_i` and `sda_i` each pass through a two-flop synchroniser. On each check, a synchronised SDA level of 1 ends the clocking loop. If SDA is already high at the first check, no SCL pulse is issued.
- R4: Each recovery pulse asserts `scl_oe_o` for exactly DELAY_CYCLES cycles and then releases it for exactly DELAY_CYCLES cycles before SDA is checked again.
- R5: If synchronised SDA is still low after MAX_PULSES recovery pulses, the block issues no further pulse, no START/STOP, and finishes with `error_o` = 1.
- R6: Before each recovery pulse, the synchronised SCL is checked. If it is low, the block waits DELAY_CYCLES cycles and checks again. It asserts `scl_oe_o` only after a check reads SCL high.
- R7: If SCL reads low on MAX_POLLS+1 successive checks, the block gives up and finishes with `error_o` = 1 without pulsing SCL.
- R8: After SDA is free, the block steps through four phases of DELAY_CYCLES cycles each, in this order: `sda_oe_o` asserted alone; both enables asserted; `sda_oe_o` asserted alone again; both released.
- R9: The final cycle of a sequence has `done_o` = `reinit_req_o` = 1 for exactly one cycle, with both output enables at 0. `owns_bus_o` is 0 from the next cycle.
- R10: `error_o` rises only in the done cycle of a failed sequence. It then holds until the next accepted start, which clears it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a recovery sequence |
| scl_i | input | 1 | Raw level read from the SCL pin |
| sda_i | input | 1 | Raw level read from the SDA pin |
| scl_oe_o | output | 1 | Pull SCL low when 1, release when 0 |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |
| owns_bus_o | output | 1 | Pins are under this block's control |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| reinit_req_o | output | 1 | One-cycle request to reinitialise the normal controller |
| error_o | output | 1 | Last sequence failed; held until the next start |

## Verification
A wrong state or counter inside the sequencer shows up at the output enables within one cycle of the divergence. A miscounted interval shortens or lengthens an SCL low phase. A lost SDA or SCL check issues a pulse that should not happen, or skips one. A wrong limit changes how many pulses appear before the done cycle. The bench model follows the same synchronised inputs that the open-drain bus and target models produce, and compares every output on every clock. Wedge, stretch and timeout cases therefore fail at the first differing cycle, not only at the end of a run.

// File: rtl/unw_pkg.sv
package unw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_STRETCH,
    ST_POLLWAIT,
    ST_PULSE_LO,
    ST_PULSE_HI,
    ST_SS_SDA_LO,
    ST_SS_SCL_LO,
    ST_SS_SCL_REL,
    ST_SS_SDA_REL,
    ST_FINISH
  } unw_state_e;

  function automatic logic pulls_scl(unw_state_e s);
    return (s == ST_PULSE_LO) || (s == ST_SS_SCL_LO);
  endfunction

  function automatic logic pulls_sda(unw_state_e s);
    return (s == ST_SS_SDA_LO) || (s == ST_SS_SCL_LO) || (s == ST_SS_SCL_REL);
  endfunction

endpackage

// File: rtl/unw_sync.sv
module unw_sync #(
  parameter int              WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic meta_q;
      logic stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= RST_VAL[g];
          stab_q <= RST_VAL[g];
        end else begin
          meta_q <= d_i[g];
          stab_q <= meta_q;
        end
      end
      assign q_o[g] = stab_q;
    end
  endgenerate

endmodule

// File: rtl/unw_interval.sv
module unw_interval #(
  parameter int DELAY_CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic expire_o
);

  localparam int CW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = (cnt_q == LAST);

  AST_INTERVAL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R4

endmodule

// File: rtl/unw_tally.sv
module unw_tally #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_limit_o = (cnt_q == TOP);

  AST_TALLY_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i) |-> (cnt_q < TOP)); // R5 R7

endmodule

// File: rtl/i2c_unwedge_seq.sv
module i2c_unwedge_seq
  import unw_pkg::*;
#(
  parameter int DELAY_CYCLES = 2500,
  parameter int MAX_PULSES   = 1000,
  parameter int MAX_POLLS    = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic owns_bus_o,
  output logic done_o,
  output logic reinit_req_o,
  output logic error_o
);

  unw_state_e st_q, st_d;
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       tmr_exp, tmr_restart;
  logic       pulse_lim, poll_lim;
  logic       accept, fail_d, err_q;

  // Two-flop synchronisers on both pins; idle bus reads high.
  unw_sync #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  assign accept = start_i && (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    fail_d = 1'b0;
    unique case (st_q)
      ST_IDLE:       if (start_i) st_d = ST_CHECK;
      ST_CHECK: begin
        if (sda_s) begin
          st_d = ST_SS_SDA_LO;
        end else if (pulse_lim) begin
          st_d   = ST_FINISH;
          fail_d = 1'b1;
        end else begin
          st_d = ST_STRETCH;
        end
      end
      ST_STRETCH: begin
        if (scl_s) begin
          st_d = ST_PULSE_LO;
        end else if (poll_lim) begin
          st_d   = ST_FINISH;
          fail_d = 1'b1;
        end else begin
          st_d = ST_POLLWAIT;
        end
      end
      ST_POLLWAIT:   if (tmr_exp) st_d = ST_STRETCH;
      ST_PULSE_LO:   if (tmr_exp) st_d = ST_PULSE_HI;
      ST_PULSE_HI:   if (tmr_exp) st_d = ST_CHECK;
      ST_SS_SDA_LO:  if (tmr_exp) st_d = ST_SS_SCL_LO;
      ST_SS_SCL_LO:  if (tmr_exp) st_d = ST_SS_SCL_REL;
      ST_SS_SCL_REL: if (tmr_exp) st_d = ST_SS_SDA_REL;
      ST_SS_SDA_REL: if (tmr_exp) st_d = ST_FINISH;
      ST_FINISH:     st_d = ST_IDLE;
      default:       st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        err_q <= 1'b0;
      end else if (fail_d) begin
        err_q <= 1'b1;
      end
    end
  end

  // Every state change restarts the shared interval.
  assign tmr_restart = (st_d != st_q);

  unw_interval #(.DELAY_CYCLES(DELAY_CYCLES)) u_interval (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (tmr_restart),
    .expire_o  (tmr_exp)
  );

  unw_tally #(.LIMIT(MAX_PULSES)) u_pulses (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (accept),
    .inc_i      ((st_q == ST_PULSE_HI) && tmr_exp),
    .at_limit_o (pulse_lim)
  );

  unw_tally #(.LIMIT(MAX_POLLS)) u_polls (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (st_q == ST_CHECK),
    .inc_i      ((st_q == ST_POLLWAIT) && tmr_exp),
    .at_limit_o (poll_lim)
  );

  assign scl_oe_o     = pulls_scl(st_q);
  assign sda_oe_o     = pulls_sda(st_q);
  assign owns_bus_o   = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_FINISH);
  assign reinit_req_o = (st_q == ST_FINISH);
  assign error_o      = err_q;

  AST_START_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !owns_bus_o) |=> owns_bus_o); // R2
  AST_BUSY_START_HARMLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && owns_bus_o && !done_o) |=> owns_bus_o); // R2
  AST_SS_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(sda_s)); // R3
  AST_PULSE_AFTER_HIGH_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_oe_o) && !sda_oe_o) |-> $past(scl_s)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !owns_bus_o); // R9
  AST_ERR_RISES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_o) |-> done_o); // R10
  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !owns_bus_o) |=> !error_o); // R10

endmodule

// File: tb/i2c_unwedge_seq_bench.sv
module i2c_unwedge_seq_bench;
  localparam int D  = 3;
  localparam int MP = 4;
  localparam int MQ = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_drv = 1'b0, scl_drv = 1'b1, sda_drv = 1'b1;
  logic scl_oe, sda_oe, owns, done, reinit, err;

  always #2 clk = ~clk;

  i2c_unwedge_seq #(.DELAY_CYCLES(D), .MAX_PULSES(MP), .MAX_POLLS(MQ)) u_i2c_unwedge_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_drv), .scl_i(scl_drv), .sda_i(sda_drv),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .owns_bus_o(owns), .done_o(done),
    .reinit_req_o(reinit), .error_o(err)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  // Behavioural expectations
  logic e_scl = 0, e_sda = 0, e_own = 0, e_done = 0, e_err = 0;
  logic m1 = 1, m2 = 1, n1 = 1, n2 = 1;
  // Bus / target environment
  int  pulses_seen = 0, ss_seen = 0, done_seen = 0;
  int  hold_scl = 0;      // >0 cycles left, -1 forever
  bit  sda_stuck = 0;
  int  release_n = 0;     // -1 never
  logic prev_scl_oe = 0, prev_sda_oe = 0;

  task automatic cmp(string tag, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %b expected %b", tag, cyc, got, exp);
    end
  endtask

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Model view of the synchronised pins
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m1 <= 1; m2 <= 1; n1 <= 1; n2 <= 1; end
    else begin m1 <= sda_drv; m2 <= m1; n1 <= scl_drv; n2 <= n1; end
  end

  task automatic model_seq();
    int pulses;
    int polls;
    bit fail;
    pulses = 0; fail = 0;
    e_own = 1; e_err = 0;
    forever begin
      @(posedge clk);
      if (m2) break;
      if (pulses == MP) begin fail = 1; break; end
      polls = 0;
      forever begin
        @(posedge clk);
        if (n2) break;
        if (polls == MQ) begin fail = 1; break; end
        repeat (D) @(posedge clk);
        polls++;
      end
      if (fail) break;
      e_scl = 1; repeat (D) @(posedge clk);
      e_scl = 0; repeat (D) @(posedge clk);
      pulses++;
    end
    if (!fail) begin
      e_sda = 1; repeat (D) @(posedge clk);
      e_scl = 1; repeat (D) @(posedge clk);
      e_scl = 0; repeat (D) @(posedge clk);
      e_sda = 0; repeat (D) @(posedge clk);
    end
    e_done = 1; e_err = fail;
    @(posedge clk);
    e_done = 0; e_own = 0;
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      if (start_drv) model_seq();
    end
  end

  // Per-cycle comparison and open-drain bus with target models
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      cmp("R4 R6 R8 scl_oe", scl_oe, e_scl);
      cmp("R3 R8 sda_oe", sda_oe, e_sda);
      cmp("R2 owns_bus", owns, e_own);
      cmp("R9 done", done, e_done);
      cmp("R9 reinit_req", reinit, e_done);
      cmp("R10 error", err, e_err);
    end
    if (scl_oe && !prev_scl_oe && !sda_oe) pulses_seen++;
    if (sda_oe && !prev_sda_oe) ss_seen++;
    if (done) done_seen++;
    prev_scl_oe = scl_oe;
    prev_sda_oe = sda_oe;
    if (hold_scl > 0) hold_scl--;
    scl_drv = !scl_oe && (hold_scl == 0);
    sda_drv = !sda_oe && !(sda_stuck && (release_n < 0 || pulses_seen < release_n));
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  task automatic run_case(bit stuck, int rel, int hold, bit busy_start);
    int t;
    int d0;
    sda_stuck = stuck; release_n = rel; hold_scl = hold;
    pulses_seen = 0; ss_seen = 0;
    repeat (5) @(negedge clk);
    d0 = done_seen;
    start_drv = 1; @(negedge clk); start_drv = 0;
    if (busy_start) begin
      repeat (6) @(negedge clk);
      start_drv = 1; @(negedge clk); start_drv = 0;
    end
    t = 0;
    while (done_seen == d0 && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) chk("watchdog wait for done", 0, 1);
    repeat (6) @(negedge clk);
    chk("R9 one done per sequence", done_seen - d0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 scl_oe in reset", int'(scl_oe), 0);
    chk("R1 sda_oe in reset", int'(sda_oe), 0);
    chk("R1 owns in reset", int'(owns), 0);
    chk("R1 done/error in reset", int'(done | reinit | err), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", int'(owns | scl_oe | sda_oe | err), 0);

    // Bus already free: no pulses, straight to START/STOP
    run_case(0, 0, 0, 0);
    chk("R3 no pulses on free bus", pulses_seen, 0);
    chk("R8 start/stop issued", ss_seen, 1);
    chk("R10 no error", int'(err), 0);

    // Target releases SDA after three pulses
    run_case(1, 3, 0, 0);
    chk("R3 pulses until SDA free", pulses_seen, 3);
    chk("R8 start/stop after recovery", ss_seen, 1);
    chk("R10 no error", int'(err), 0);

    // SDA never released: pulse limit
    run_case(1, -1, 0, 0);
    chk("R5 pulse count at limit", pulses_seen, MP);
    chk("R5 no start/stop on failure", ss_seen, 0);
    chk("R5 error set", int'(err), 1);
    repeat (10) @(negedge clk);
    chk("R10 error held while idle", int'(err), 1);

    // Clock stretched for a while, then one pulse frees SDA
    run_case(1, 1, 7, 0);
    chk("R6 pulse after stretch", pulses_seen, 1);
    chk("R10 error cleared by new start", int'(err), 0);

    // SCL held forever: stretch timeout
    run_case(1, -1, -1, 0);
    chk("R7 no pulses on stretch timeout", pulses_seen, 0);
    chk("R7 error set", int'(err), 1);
    hold_scl = 0;

    // Start while busy is ignored
    run_case(1, 2, 0, 1);
    chk("R2 busy start no extra pulses", pulses_seen, 2);
    chk("R2 idle after sequence", int'(owns), 0);
    chk("R10 error cleared", int'(err), 0);

    summary();
  end

endmodule